// File: doc/BRIEF.md
# ADC Sequencer Trigger and Timing Controller

This block is the digital control side of a successive-approximation converter. Software programs it through a small word-addressed register port. The block derives the converter clock from the system clock with a power-of-two prescaler. After an enable request it waits out an optional startup delay. It then launches conversions from one selected trigger source: a software strobe, an internal reload timer, an on-chip trigger line, free-running back-to-back operation, or an external pin on a rising edge, a falling edge or both. Each result is stored, together with its channel numbers, in a last-value register. The block keeps sticky status flags with a write-one clear and a separate interrupt mask. Inside the block, a behavioural converter model holds the input code at launch and reports it after a fixed number of converter clocks.

The enable state machine has three states. EN_OFF goes to EN_WAIT on an enable request when startup is enabled, and goes to EN_ON directly when it is not. EN_WAIT goes to EN_ON after the startup count of converter clocks. Any state goes to EN_OFF on a disable request. The sequencer state machine also has three states. SQ_IDLE goes to SQ_LAUNCH when the block is enabled and a trigger event arrives or continuous mode is selected. SQ_LAUNCH always goes to SQ_CONV; this is the cycle that starts the converter. SQ_CONV goes back to SQ_LAUNCH when the converter finishes in continuous mode while the block is still enabled, and to SQ_IDLE otherwise. A software reset forces SQ_IDLE.

Top module: `adc_seq_ctrl`

Register map (word address, 4 bits):

| Addr | Register | Access | Fields |
|---|---|---|---|
| 0 | CTRL | write strobes | bit 0 soft reset, bit 1 enable, bit 2 disable, bit 3 software trigger, bit 4 timer start, bit 5 timer stop |
| 1 | CFG | read/write | [2:0] prescaler N |
| 2 | SEQ | read/write | [2:0] trigger select, [4] 8-bit result, [5] left adjust, [11:8] positive channel, [14:12] negative channel |
| 3 | TIM | read/write | [4:0] startup count, [8] startup enable |
| 4 | ITMR | read/write | [15:0] timer reload |
| 5 | STAT | read only | [5:0] flags, [8] enabled, [9] timer running, [10] sequencer busy, [11] converter busy |
| 6 | SCLR | write 1 to clear | [5:0] flags |
| 7 | LAST | read only | [15:0] value, [19:16] positive channel, [22:20] negative channel |
| 8 | MSET | write 1 to set | [5:0] mask |
| 9 | MCLR | write 1 to clear | [5:0] mask |
| 10 | MASK | read only | [5:0] mask |

The flag bits are: 0 end of conversion, 1 overrun, 3 missed trigger, 5 timer timeout. Bits 2 and 4 read as zero.

## Requirements
- R1: The converter clock ticks once every 4·2^N system clocks, where N is CFG[2:0], and a conversion takes 8 converter clocks. In continuous mode, successive end-of-conversion events are therefore exactly 8·4·2^N system clocks apart.
- R2: With TIM[8]=1, an enable request sets STAT[8] no earlier than STARTUP and no later than STARTUP+2 converter clocks later. With TIM[8]=0, STAT[8] is set on the next clock. A disable request clears STAT[8].
- R3: With trigger select 0, a write of 1 to CTRL bit 3 starts one conversion, and STAT[0] is set when it completes.
- R4: With trigger select 1 and the timer started, STAT[5] is set every (reload+1) converter clocks, each expiry starts a conversion, and STAT[9] reads 1 from timer start until timer stop.
- R5: With trigger select 2, a one-cycle high pulse on int_trig_i starts a conversion.
- R6: With trigger select 3, conversions repeat without any trigger until the select changes.
- R7: Trigger selects 4, 5 and 6 start a conversion on a rising edge, a falling edge, or either edge of ext_trig_i. The pin passes through a two-flop synchronizer, and an edge of the wrong direction starts nothing.
- R8: LAST holds the result in bits 15:0, the positive channel in bits 19:16 and the negative channel in bits 22:20. With SEQ[4]=0 the 12-bit code is used; with SEQ[4]=1 its upper 8 bits are used. The value is right-justified, or, with SEQ[5]=1, shifted to the top of the 16 bits.
- R9: A result that completes while STAT[0] is still set also sets STAT[1].
- R10: A trigger event that arrives while the sequencer is busy sets STAT[3] and starts nothing extra.
- R11: Writing 1s to SCLR clears those flags. MSET and MCLR set and clear mask bits. irq_o is high exactly when some flag is set and its mask bit is 1.
- R12: Soft reset clears the flags and LAST, stops the timer and the sequencer, and leaves CFG, SEQ, TIM, ITMR, the mask and STAT[8] unchanged.
- R13: While STAT[8] is 0, trigger events start no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock and prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| int_trig_i | input | 1 | On-chip trigger line, synchronous pulses |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| ana_code_i | input | 12 | Code returned by the behavioural converter model |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The assertions assume that int_trig_i and reg_we are synchronous to clk. They also assume that ana_code_i holds steady around each launch cycle and that only ext_trig_i may change at any time. The bench drives every input on the falling clock edge and keeps ana_code_i fixed from before the trigger until the end of conversion is seen. It changes the prescaler and the trigger select only while the sequencer is idle, so that the interval checks see a steady converter clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CODE_W = 12;
    localparam int RES_W  = 16;
    localparam int FLAG_W = 6;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CFG  = 4'd1;
    localparam logic [3:0] A_SEQ  = 4'd2;
    localparam logic [3:0] A_TIM  = 4'd3;
    localparam logic [3:0] A_ITMR = 4'd4;
    localparam logic [3:0] A_STAT = 4'd5;
    localparam logic [3:0] A_SCLR = 4'd6;
    localparam logic [3:0] A_LAST = 4'd7;
    localparam logic [3:0] A_MSET = 4'd8;
    localparam logic [3:0] A_MCLR = 4'd9;
    localparam logic [3:0] A_MASK = 4'd10;

    localparam int F_EOC  = 0;
    localparam int F_OVR  = 1;
    localparam int F_MISS = 3;
    localparam int F_TTO  = 5;

    localparam logic [2:0] TS_SW   = 3'd0;
    localparam logic [2:0] TS_TMR  = 3'd1;
    localparam logic [2:0] TS_INT  = 3'd2;
    localparam logic [2:0] TS_CONT = 3'd3;
    localparam logic [2:0] TS_RISE = 3'd4;
    localparam logic [2:0] TS_FALL = 3'd5;
    localparam logic [2:0] TS_BOTH = 3'd6;

    typedef enum logic [1:0] {EN_OFF, EN_WAIT, EN_ON} en_state_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_CONV} sq_state_e;

    function automatic logic [RES_W-1:0] place_result(input logic [CODE_W-1:0] code,
                                                     input logic res8, input logic ladj);
        logic [RES_W-1:0] v;
        if (res8) v = ladj ? {code[11:4], 8'h00} : {8'h00, code[11:4]};
        else      v = ladj ? {code, 4'h0}        : {4'h0, code};
        return v;
    endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
    parameter int PRESC_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    localparam int CNT_W = (1 << PRESC_W) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   div_m1;

    assign div_m1 = ((CNT_W+1)'(4) << presc) - (CNT_W+1)'(1);
    assign tick   = ({1'b0, cnt_q} >= div_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_edge_sync.sv
module adc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], pin};
    end

    assign rise = sh_q[1] & ~sh_q[2];
    assign fall = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/adc_conv_model.sv
module adc_conv_model #(
    parameter int CONV_TICKS = 8,
    parameter int CODE_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic              tick,
    input  logic [CODE_W-1:0] code_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o
);
    localparam int CNT_W = (CONV_TICKS > 2) ? $clog2(CONV_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(CONV_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done_o = busy_o & tick & (cnt_q == LAST_TICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            cnt_q    <= '0;
            result_o <= '0;
        end else if (abort) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_o   <= 1'b1;
            cnt_q    <= '0;
            result_o <= code_i;
        end else if (busy_o && tick) begin
            if (cnt_q == LAST_TICK) busy_o <= 1'b0;
            else                    cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int PRESC_W    = 3,
    parameter int STUP_W     = 5,
    parameter int TMR_W      = 16,
    parameter int CONV_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        int_trig_i,
    input  logic        ext_trig_i,
    input  logic [11:0] ana_code_i,
    output logic        irq_o
);
    // register decode
    logic wr_ctl, wr_cfg, wr_seq, wr_tim, wr_itmr, wr_sclr, wr_mset, wr_mclr;
    assign wr_ctl  = reg_we && (reg_addr == A_CTRL);
    assign wr_cfg  = reg_we && (reg_addr == A_CFG);
    assign wr_seq  = reg_we && (reg_addr == A_SEQ);
    assign wr_tim  = reg_we && (reg_addr == A_TIM);
    assign wr_itmr = reg_we && (reg_addr == A_ITMR);
    assign wr_sclr = reg_we && (reg_addr == A_SCLR);
    assign wr_mset = reg_we && (reg_addr == A_MSET);
    assign wr_mclr = reg_we && (reg_addr == A_MCLR);

    logic swrst, en_req, dis_req, strig, tstart, tstop;
    assign swrst   = wr_ctl & reg_wdata[0];
    assign en_req  = wr_ctl & reg_wdata[1];
    assign dis_req = wr_ctl & reg_wdata[2];
    assign strig   = wr_ctl & reg_wdata[3];
    assign tstart  = wr_ctl & reg_wdata[4];
    assign tstop   = wr_ctl & reg_wdata[5];

    // configuration registers
    logic [PRESC_W-1:0] presc_q;
    logic [2:0]         tsel_q;
    logic               res8_q, ladj_q;
    logic [3:0]         pos_q;
    logic [2:0]         neg_q;
    logic [STUP_W-1:0]  stup_len_q;
    logic               stup_en_q;
    logic [TMR_W-1:0]   reload_q;
    logic [FLAG_W-1:0]  mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q    <= '0;
            tsel_q     <= TS_SW;
            res8_q     <= 1'b0;
            ladj_q     <= 1'b0;
            pos_q      <= '0;
            neg_q      <= '0;
            stup_len_q <= '0;
            stup_en_q  <= 1'b0;
            reload_q   <= '0;
            mask_q     <= '0;
        end else begin
            if (wr_cfg) presc_q <= reg_wdata[PRESC_W-1:0];
            if (wr_seq) begin
                tsel_q <= reg_wdata[2:0];
                res8_q <= reg_wdata[4];
                ladj_q <= reg_wdata[5];
                pos_q  <= reg_wdata[11:8];
                neg_q  <= reg_wdata[14:12];
            end
            if (wr_tim) begin
                stup_len_q <= reg_wdata[STUP_W-1:0];
                stup_en_q  <= reg_wdata[8];
            end
            if (wr_itmr) reload_q <= reg_wdata[TMR_W-1:0];
            if (wr_mset) mask_q <= mask_q | reg_wdata[FLAG_W-1:0];
            else if (wr_mclr) mask_q <= mask_q & ~reg_wdata[FLAG_W-1:0];
        end
    end

    // converter clock, pin synchronizer, converter model
    logic tick, ext_rise, ext_fall;
    logic conv_start, conv_busy, conv_done;
    logic [CODE_W-1:0] conv_result;

    adc_clkdiv #(.PRESC_W(PRESC_W)) clkdiv_i (
        .clk(clk), .rst_n(rst_n), .presc(presc_q), .tick(tick));

    adc_edge_sync sync_i (
        .clk(clk), .rst_n(rst_n), .pin(ext_trig_i), .rise(ext_rise), .fall(ext_fall));

    adc_conv_model #(.CONV_TICKS(CONV_TICKS), .CODE_W(CODE_W)) conv_i (
        .clk(clk), .rst_n(rst_n), .abort(swrst), .start(conv_start), .tick(tick),
        .code_i(ana_code_i), .busy_o(conv_busy), .done_o(conv_done), .result_o(conv_result));

    // enable state machine
    en_state_e en_q, en_nxt;
    logic [STUP_W-1:0] stup_cnt_q;
    logic en_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= EN_OFF;
        else        en_q <= en_nxt;
    end

    always_comb begin
        en_nxt = en_q;
        unique case (en_q)
            EN_OFF:  if (en_req) en_nxt = stup_en_q ? EN_WAIT : EN_ON;
            EN_WAIT: if (tick && (stup_cnt_q == stup_len_q)) en_nxt = EN_ON;
            EN_ON:   en_nxt = EN_ON;
            default: en_nxt = EN_OFF;
        endcase
        if (dis_req) en_nxt = EN_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      stup_cnt_q <= '0;
        else if (en_q != EN_WAIT)        stup_cnt_q <= '0;
        else if (tick)                   stup_cnt_q <= stup_cnt_q + 1'b1;
    end

    assign en_on = (en_q == EN_ON);

    // internal reload timer
    logic             tmr_run_q, tmr_fire;
    logic [TMR_W-1:0] tmr_cnt_q;

    assign tmr_fire = tmr_run_q & tick & (tmr_cnt_q == reload_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_run_q <= 1'b0;
            tmr_cnt_q <= '0;
        end else if (swrst || tstop) begin
            tmr_run_q <= 1'b0;
            tmr_cnt_q <= '0;
        end else if (tstart) begin
            tmr_run_q <= 1'b1;
            tmr_cnt_q <= '0;
        end else if (tmr_run_q && tick) begin
            tmr_cnt_q <= tmr_fire ? '0 : tmr_cnt_q + 1'b1;
        end
    end

    // trigger selection
    logic trig_evt, cont_mode;
    always_comb begin
        unique case (tsel_q)
            TS_SW:   trig_evt = strig;
            TS_TMR:  trig_evt = tmr_fire;
            TS_INT:  trig_evt = int_trig_i;
            TS_RISE: trig_evt = ext_rise;
            TS_FALL: trig_evt = ext_fall;
            TS_BOTH: trig_evt = ext_rise | ext_fall;
            default: trig_evt = 1'b0;
        endcase
        trig_evt = trig_evt & en_on;
    end
    assign cont_mode = (tsel_q == TS_CONT);

    // sequencer state machine
    sq_state_e sq_q, sq_nxt;
    logic sq_idle, missed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= SQ_IDLE;
        else        sq_q <= sq_nxt;
    end

    always_comb begin
        sq_nxt = sq_q;
        unique case (sq_q)
            SQ_IDLE:   if (en_on && (trig_evt || cont_mode)) sq_nxt = SQ_LAUNCH;
            SQ_LAUNCH: sq_nxt = SQ_CONV;
            SQ_CONV:   if (conv_done) sq_nxt = (cont_mode && en_on) ? SQ_LAUNCH : SQ_IDLE;
            default:   sq_nxt = SQ_IDLE;
        endcase
        if (swrst) sq_nxt = SQ_IDLE;
    end

    always_comb begin
        sq_idle    = (sq_q == SQ_IDLE);
        conv_start = (sq_q == SQ_LAUNCH) && !swrst;
        missed     = trig_evt && !sq_idle;
    end

    // flags and last value
    logic [FLAG_W-1:0] flags_q, flag_set, flag_clr;
    logic [22:0]       last_q;

    always_comb begin
        flag_set         = '0;
        flag_set[F_EOC]  = conv_done;
        flag_set[F_OVR]  = conv_done & flags_q[F_EOC];
        flag_set[F_MISS] = missed;
        flag_set[F_TTO]  = tmr_fire;
        flag_clr         = wr_sclr ? reg_wdata[FLAG_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            last_q  <= '0;
        end else if (swrst) begin
            flags_q <= '0;
            last_q  <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            if (conv_done) last_q <= {neg_q, pos_q, place_result(conv_result, res8_q, ladj_q)};
        end
    end

    assign irq_o = |(flags_q & mask_q);

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CFG:  reg_rdata[PRESC_W-1:0] = presc_q;
            A_SEQ:  reg_rdata[14:0] = {neg_q, pos_q, 2'b00, ladj_q, res8_q, 1'b0, tsel_q};
            A_TIM:  reg_rdata[8:0]  = {stup_en_q, 3'b000, stup_len_q};
            A_ITMR: reg_rdata[TMR_W-1:0] = reload_q;
            A_STAT: reg_rdata[11:0] = {conv_busy, !sq_idle, tmr_run_q, en_on, 2'b00, flags_q};
            A_LAST: reg_rdata[22:0] = last_q;
            A_MASK: reg_rdata[FLAG_W-1:0] = mask_q;
            default: reg_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] flags,
    input logic       conv_busy,
    input logic       sq_idle,
    input logic       en_on,
    input logic       conv_start,
    input logic       swrst
);
    // R9: overrun only rises when an earlier end-of-conversion was pending
    a_r9_ovr_needs_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(flags[0]));

    // R10: missed trigger only rises while the sequencer was busy
    a_r10_miss_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> $past(!sq_idle));

    // R13: a launch only follows an enabled cycle
    a_r13_launch_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(en_on));

    // R1: a launch makes the converter busy on the next cycle
    a_r1_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> conv_busy);

    // R12: after a soft reset the sequencer and converter are idle
    a_r12_swrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> (sq_idle && !conv_busy));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .flags(flags_q), .conv_busy(conv_busy),
    .sq_idle(sq_idle), .en_on(en_on), .conv_start(conv_start), .swrst(swrst));

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_trig_i = 1'b0;
    logic        ext_trig_i = 1'b0;
    logic [11:0] ana_code_i = '0;
    logic        irq_o;

    int nchk = 0;
    int nfail = 0;
    int unsigned cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_ctrl dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] seqw(input logic [2:0] sel, input logic r8, input logic la,
                                         input logic [3:0] p, input logic [2:0] n);
        return {17'b0, n, p, 2'b00, la, r8, 1'b0, sel};
    endfunction

    function automatic logic [31:0] exp_last(input logic [11:0] c, input logic r8, input logic la,
                                             input logic [3:0] p, input logic [2:0] n);
        logic [15:0] v;
        if (r8) v = la ? {c[11:4], 8'h00} : {8'h00, c[11:4]};
        else    v = la ? {c, 4'h0} : {4'h0, c};
        return {9'b0, n, p, v};
    endfunction

    task automatic wait_irq(output int unsigned t);
        int k = 0;
        while (irq_o !== 1'b1 && k < 5000) begin @(negedge clk); k++; end
        t = cyc;
    endtask

    // time between two consecutive rises of irq (flags cleared in between)
    task automatic irq_period(output int unsigned p);
        int unsigned t0, t1;
        wr(4'd6, 32'h3f);
        wait_irq(t0);
        wr(4'd6, 32'h3f);
        wait_irq(t1);
        p = t1 - t0;
    endtask

    logic [31:0] d;
    int unsigned per;

    initial begin
        #3_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        rd(4'd5, d);  chk("R11 reset STAT", d, 32'h0);
        rd(4'd10, d); chk("R11 reset MASK", d, 32'h0);
        rd(4'd7, d);  chk("R8 reset LAST", d, 32'h0);
        chk("R11 reset irq", {31'b0, irq_o}, 32'h0);

        // R13: trigger while disabled does nothing
        wr(4'd2, seqw(3'd0, 1'b0, 1'b0, 4'd1, 3'd1));
        wr(4'd0, 32'h8);
        idle(200);
        rd(4'd5, d); chk("R13 no conversion while off", d, 32'h0);

        // R2: startup delay of 10 converter clocks at div 4
        wr(4'd1, 32'h0);
        wr(4'd3, 32'h10a);
        wr(4'd0, 32'h2);
        idle(28);
        rd(4'd5, d); chk("R2 enable not yet set", {31'b0, d[8]}, 32'h0);
        idle(40);
        rd(4'd5, d); chk("R2 enable set after startup", {31'b0, d[8]}, 32'h1);

        // R3 / R8: random software-triggered conversions
        for (int i = 0; i < 24; i++) begin
            logic [11:0] c;
            logic r8, la;
            logic [3:0] p;
            logic [2:0] n;
            c = 12'($urandom); r8 = 1'($urandom); la = 1'($urandom);
            p = 4'($urandom);  n = 3'($urandom);
            if (i == 0) begin c = 12'hfff; r8 = 1'b0; la = 1'b1; end
            if (i == 1) begin c = 12'h001; r8 = 1'b1; la = 1'b0; end
            ana_code_i = c;
            wr(4'd2, seqw(3'd0, r8, la, p, n));
            wr(4'd0, 32'h8);
            idle(50);
            rd(4'd5, d); chk("R3 eoc after software trigger", {31'b0, d[0]}, 32'h1);
            rd(4'd7, d); chk("R8 last value layout", d, exp_last(c, r8, la, p, n));
            wr(4'd6, 32'h1);
            rd(4'd5, d); chk("R11 eoc cleared", {31'b0, d[0]}, 32'h0);
        end

        // R9: overrun
        wr(4'd0, 32'h8); idle(50);
        wr(4'd0, 32'h8); idle(50);
        rd(4'd5, d); chk("R9 overrun set", d[5:0], 32'h3);
        wr(4'd6, 32'h3f);

        // R10: missed trigger
        wr(4'd0, 32'h8);
        wr(4'd0, 32'h8);
        idle(50);
        rd(4'd5, d); chk("R10 missed trigger, single eoc", d[5:0], 32'h9);
        wr(4'd6, 32'h3f);

        // R11: mask and irq
        wr(4'd8, 32'h21);
        rd(4'd10, d); chk("R11 mask set", d, 32'h21);
        wr(4'd0, 32'h8); idle(50);
        chk("R11 irq with masked eoc", {31'b0, irq_o}, 32'h1);
        wr(4'd9, 32'h1);
        rd(4'd5, d);
        chk("R11 irq low after mask clear", {30'b0, irq_o, d[0]}, 32'h1);
        wr(4'd6, 32'h3f);

        // R1 / R6: continuous mode at N=0 and N=1
        wr(4'd8, 32'h1);
        wr(4'd2, seqw(3'd3, 1'b0, 1'b0, 4'd0, 3'd0));
        irq_period(per); irq_period(per);
        chk("R1 R6 continuous period N=0", per, 32'd32);
        wr(4'd2, seqw(3'd0, 1'b0, 1'b0, 4'd0, 3'd0));
        idle(100);
        wr(4'd1, 32'h1);
        wr(4'd2, seqw(3'd3, 1'b0, 1'b0, 4'd0, 3'd0));
        irq_period(per); irq_period(per);
        chk("R1 R6 continuous period N=1", per, 32'd64);
        wr(4'd2, seqw(3'd0, 1'b0, 1'b0, 4'd0, 3'd0));
        idle(200);
        wr(4'd1, 32'h0);
        wr(4'd6, 32'h3f);
        rd(4'd5, d); chk("R6 stops after select change", d[11:10], 32'h0);

        // R4: timer trigger, reload 19 -> 20 converter clocks = 80 cycles
        wr(4'd9, 32'h3f);
        wr(4'd8, 32'h20);
        wr(4'd4, 32'd19);
        wr(4'd2, seqw(3'd1, 1'b0, 1'b0, 4'd2, 3'd0));
        wr(4'd0, 32'h10);
        rd(4'd5, d); chk("R4 timer busy", {31'b0, d[9]}, 32'h1);
        irq_period(per); irq_period(per);
        chk("R4 timer period", per, 32'd80);
        idle(60);
        rd(4'd5, d); chk("R4 timer started conversion", {31'b0, d[0]}, 32'h1);
        wr(4'd0, 32'h20);
        rd(4'd5, d); chk("R4 timer stopped", {31'b0, d[9]}, 32'h0);
        idle(60);
        wr(4'd6, 32'h3f);
        wr(4'd9, 32'h3f);

        // R5: internal trigger
        wr(4'd2, seqw(3'd2, 1'b0, 1'b0, 4'd0, 3'd0));
        @(negedge clk); int_trig_i = 1'b1;
        @(negedge clk); int_trig_i = 1'b0;
        idle(50);
        rd(4'd5, d); chk("R5 internal trigger eoc", {31'b0, d[0]}, 32'h1);
        wr(4'd6, 32'h3f);

        // R7: external edges
        wr(4'd2, seqw(3'd4, 1'b0, 1'b0, 4'd0, 3'd0));
        ext_trig_i = 1'b1; idle(60);
        rd(4'd5, d); chk("R7 rising edge mode, rise", {31'b0, d[0]}, 32'h1);
        wr(4'd6, 32'h3f);
        ext_trig_i = 1'b0; idle(60);
        rd(4'd5, d); chk("R7 rising edge mode, fall ignored", {31'b0, d[0]}, 32'h0);
        wr(4'd2, seqw(3'd5, 1'b0, 1'b0, 4'd0, 3'd0));
        ext_trig_i = 1'b1; idle(60);
        rd(4'd5, d); chk("R7 falling edge mode, rise ignored", {31'b0, d[0]}, 32'h0);
        ext_trig_i = 1'b0; idle(60);
        rd(4'd5, d); chk("R7 falling edge mode, fall", {31'b0, d[0]}, 32'h1);
        wr(4'd6, 32'h3f);
        wr(4'd2, seqw(3'd6, 1'b0, 1'b0, 4'd0, 3'd0));
        ext_trig_i = 1'b1; idle(60);
        rd(4'd5, d); chk("R7 both edges, rise", {31'b0, d[0]}, 32'h1);
        wr(4'd6, 32'h3f);
        ext_trig_i = 1'b0; idle(60);
        rd(4'd5, d); chk("R7 both edges, fall", {31'b0, d[0]}, 32'h1);

        // R12: soft reset mid-conversion with timer running
        wr(4'd1, 32'h2);
        wr(4'd8, 32'h8);
        wr(4'd2, seqw(3'd0, 1'b1, 1'b1, 4'd9, 3'd5));
        wr(4'd0, 32'h18);
        wr(4'd0, 32'h1);
        rd(4'd5, d); chk("R12 status after soft reset", d, 32'h100);
        rd(4'd7, d); chk("R12 last cleared", d, 32'h0);
        rd(4'd1, d); chk("R12 cfg kept", d, 32'h2);
        rd(4'd2, d); chk("R12 seq kept", d, seqw(3'd0, 1'b1, 1'b1, 4'd9, 3'd5));
        rd(4'd10, d); chk("R12 mask kept", d, 32'h8);

        // R2: disable clears enable; R13 trigger then ignored
        wr(4'd0, 32'h4);
        wr(4'd0, 32'h8);
        idle(300);
        rd(4'd5, d); chk("R2 R13 disabled, no conversion", d, 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule